// File: doc/BRIEF.md
# Addressed Serial Port Expander Slave

This block is a serial slave that gives a host an 8-bit parallel port over three wires: an active-low frame select, a serial clock and a data-in line, with one data-out line back to the host. Every frame carries 16 bits, most significant bit first: a 5-bit device address, then a 3-bit command, then an 8-bit data byte. The address is checked against five strap inputs. On a match the slave pulls data-out low as an acknowledge. When the command is all ones, it then shifts out the port value that it sampled when the frame opened.

When the select line is released, the slave inverts the received data byte and writes it to the parallel output latch. This happens only if exactly 16 serial clocks arrived in the frame. Frames of any other length leave the latch alone. The serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and every edge is detected in the system clock domain. Data-out therefore responds about three system clocks after the serial edge that causes the change.

Top module: `sio_expander`

## Requirements
- R1: After reset, `port_o` is 8'h00 and `sdo_o` is 1.
- R2: The port byte that is shifted out is the value of `port_i` at the falling edge of `sel_n_i`; later changes to `port_i` within the frame do not alter it.
- R3: Bits are taken on rising `sck_i` edges in this order: address bit 4 down to 0, command bit 2 down to 0, data bit 7 down to 0. Address bit 4 is compared with `strap_i[4]`, and data bit 7 maps to `port_o[7]`.
- R4: If the 5 received address bits equal `strap_i`, `sdo_o` goes low after the 8th falling `sck_i` edge. If they do not match, `sdo_o` stays 1 for the whole frame.
- R5: If the address matches and the command is not 3'b111, `sdo_o` returns to 1 at the 9th rising `sck_i` edge and stays 1 until the frame ends.
- R6: If the address matches and the command is 3'b111, the captured port byte appears on `sdo_o` bit 7 first, one bit after each of the falling `sck_i` edges 9 through 16.
- R7: When `sel_n_i` rises, `sdo_o` returns to 1, and the next frame starts its bit count from zero.
- R8: When `sel_n_i` rises after exactly 16 rising `sck_i` edges, `port_o` becomes the bitwise inverse of the last 8 received bits, whether or not the address matched. After 15 or 17 edges, `port_o` is unchanged.
- R9: The bit counter saturates and never wraps, so a frame of 80 clocks does not write the latch.
- R10: `sck_i` edges while `sel_n_i` is high change neither `port_o` nor `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low frame select, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| strap_i | input | 5 | Device address straps |
| port_i | input | 8 | Parallel port input value |
| sdo_o | output | 1 | Serial data out; idles high |
| port_o | output | 8 | Parallel output latch |

## Verification
A corrupted bit count shows at the ports within a single frame. The acknowledge moves off the 8th falling edge, the read byte shifts by one position, or the latch write is missed or fires on a 15-, 17- or 80-clock frame. A stale match or read flag leaves `sdo_o` low outside a matched frame, or drives read data after a non-read command; this is visible at the next serial falling edge. A wrong port register is visible on `port_o` a few system clocks after `sel_n_i` rises.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int ADDR_W    = 5;
    localparam int CMD_W     = 3;
    localparam int DATA_W    = 8;
    localparam int HDR_LEN   = ADDR_W + CMD_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN) + 2;

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] rx;
        logic [DATA_W-1:0]    tx;
        logic                 sdo;
        logic                 match;
        logic                 rd;
        logic [DATA_W-1:0]    port;
    } frame_st_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d, sync_q, sync_d;

    always_comb begin
        meta_d = async_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/sio_edge.sv
module sio_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q, prev_d;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sio_frame.sv
module sio_frame
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl_i,
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sdi_i,
    input  logic [ADDR_W-1:0] strap_i,
    input  logic [DATA_W-1:0] port_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] port_o
);
    localparam logic [CNT_W-1:0] HDR_CNT   = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    frame_st_t q, d;
    logic [ADDR_W-1:0] hdr_addr;
    logic [CMD_W-1:0]  hdr_cmd;
    logic              addr_hit;

    always_comb begin
        hdr_addr = q.rx[HDR_LEN-1:CMD_W];
        hdr_cmd  = q.rx[CMD_W-1:0];
        addr_hit = (hdr_addr == strap_i);
        d = q;
        if (sel_fall_i) begin
            d.cnt   = '0;
            d.rx    = '0;
            d.tx    = port_i;
            d.sdo   = 1'b1;
            d.match = 1'b0;
            d.rd    = 1'b0;
        end else if (sel_rise_i) begin
            if (q.cnt == FRAME_CNT) d.port = ~q.rx[DATA_W-1:0];
            d.cnt   = '0;
            d.sdo   = 1'b1;
            d.match = 1'b0;
            d.rd    = 1'b0;
        end else if (!sel_lvl_i) begin
            if (sck_rise_i) begin
                d.rx = {q.rx[FRAME_LEN-2:0], sdi_i};
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                if (q.cnt == HDR_CNT && q.match && !q.rd) d.sdo = 1'b1;
            end else if (sck_fall_i) begin
                if (q.cnt == HDR_CNT) begin
                    d.match = addr_hit;
                    d.rd    = addr_hit && (&hdr_cmd);
                    if (addr_hit) d.sdo = 1'b0;
                end else if (q.rd && q.cnt > HDR_CNT && q.cnt <= FRAME_CNT) begin
                    d.sdo = q.tx[DATA_W-1];
                    d.tx  = {q.tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sdo   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sdo_o  = q.sdo;
    assign port_o = q.port;

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.port != $past(q.port)) |-> $past(sel_rise_i && q.cnt == FRAME_CNT)); // R8
    AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lvl_i && $past(sel_lvl_i)) |-> q.sdo); // R7
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !q.sdo |-> q.match); // R4
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != $past(q.cnt)) |-> (q.cnt == '0 || q.cnt == $past(q.cnt) + 1'b1)); // R9
    AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.sdo) && q.cnt > HDR_CNT) |-> q.rd); // R6
endmodule

// File: rtl/sio_expander.sv
module sio_expander
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [ADDR_W-1:0] strap_i,
    input  logic [DATA_W-1:0] port_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] port_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, sync_in;
    logic sel_s, sck_s, sdi_s;
    logic sel_rise, sel_fall, sck_rise, sck_fall;

    assign raw_in = {sel_n_i, sck_i, sdi_i};

    sio_sync #(.W(NSYNC), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in)
    );

    assign {sel_s, sck_s, sdi_s} = sync_in;

    sio_edge #(.RST_VAL(1'b1)) u_sel_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sel_s), .rise_o(sel_rise), .fall_o(sel_fall)
    );

    sio_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sck_s), .rise_o(sck_rise), .fall_o(sck_fall)
    );

    sio_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sel_lvl_i(sel_s), .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
        .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sdi_i(sdi_s),
        .strap_i(strap_i), .port_i(port_i),
        .sdo_o(sdo_o), .port_o(port_o)
    );
endmodule

// File: tb/sio_expander_bench.sv
module sio_expander_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, sel_n, sck, sdi;
    logic [4:0] strap;
    logic [7:0] pin;
    logic       sdo;
    logic [7:0] pout;

    int checks = 0;
    int fails  = 0;
    logic rise_log [1:80];
    logic fall_log [1:80];

    sio_expander u_sio_expander (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
        .strap_i(strap), .port_i(pin), .sdo_o(sdo), .port_o(pout)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] bits, input int n, input logic [7:0] late_pin);
        sel_n = 1'b0;
        wclk(8);
        pin = late_pin;
        wclk(2);
        for (int i = 1; i <= n; i++) begin
            sdi = (i <= 16) ? bits[16-i] : 1'b0;
            wclk(4);
            sck = 1'b1;
            wclk(8);
            rise_log[i] = sdo;
            sck = 1'b0;
            wclk(8);
            fall_log[i] = sdo;
        end
        sel_n = 1'b1;
        wclk(8);
    endtask

    function automatic logic [7:0] falls(input int first);
        logic [7:0] v;
        for (int k = 0; k < 8; k++) v[7-k] = fall_log[first+k];
        return v;
    endfunction

    task automatic t_reset();
        chk("R1", "port after reset", 32'(pout), 32'h00);
        chk("R1", "sdo after reset", 32'(sdo), 32'h1);
    endtask

    task automatic t_read();
        logic [6:0] pre;
        strap = 5'h13;
        pin   = 8'hA5;
        frame({5'h13, 3'b111, 8'h3C}, 16, 8'h00);
        for (int k = 1; k <= 7; k++) pre[k-1] = fall_log[k];
        chk("R4", "sdo before ack", 32'(pre), 32'h7F);
        chk("R4", "ack after fall 8", 32'(fall_log[8]), 32'h0);
        chk("R6", "read byte", 32'(falls(9)), 32'hA5);
        chk("R2", "read byte ignores late port change", 32'(falls(9)), 32'hA5);
        chk("R7", "sdo after select rise", 32'(sdo), 32'h1);
        chk("R8", "port write inverted", 32'(pout), 32'hC3);
        chk("R3", "data bit order", 32'(pout[7]), 32'h1);
    endtask

    task automatic t_mismatch();
        logic [15:0] all;
        pin = 8'hFF;
        frame({5'h19, 3'b111, 8'h81}, 16, 8'hFF);
        for (int k = 1; k <= 16; k++) all[k-1] = fall_log[k] & rise_log[k];
        chk("R3", "bit reversed address no ack", 32'(all), 32'hFFFF);
        chk("R4", "mismatch sdo stays high", 32'(all), 32'hFFFF);
        chk("R8", "write regardless of address", 32'(pout), 32'h7E);
    endtask

    task automatic t_cmd();
        pin = 8'h00;
        frame({5'h13, 3'b101, 8'hF0}, 16, 8'h00);
        chk("R4", "ack with non-read command", 32'(fall_log[8]), 32'h0);
        chk("R5", "sdo high at rise 9", 32'(rise_log[9]), 32'h1);
        chk("R5", "sdo high rest of frame", 32'(falls(9)), 32'hFF);
        chk("R8", "port write after non-read", 32'(pout), 32'h0F);
    endtask

    task automatic t_length();
        frame({5'h13, 3'b111, 8'h55}, 15, 8'h00);
        chk("R8", "15-clock frame no write", 32'(pout), 32'h0F);
        frame({5'h13, 3'b111, 8'h55}, 17, 8'h00);
        chk("R8", "17-clock frame no write", 32'(pout), 32'h0F);
        frame({5'h13, 3'b111, 8'h55}, 80, 8'h00);
        chk("R9", "80-clock frame no write", 32'(pout), 32'h0F);
        chk("R7", "sdo after long frame", 32'(sdo), 32'h1);
        frame({5'h13, 3'b111, 8'h00}, 16, 8'h00);
        chk("R7", "count restarts after long frame", 32'(pout), 32'hFF);
    endtask

    task automatic t_idle();
        logic hi;
        hi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            sdi = i[0];
            wclk(4);
            sck = 1'b1;
            wclk(8);
            hi = hi & sdo;
            sck = 1'b0;
            wclk(8);
            hi = hi & sdo;
        end
        chk("R10", "sdo high with select idle", 32'(hi), 32'h1);
        chk("R10", "port unchanged with select idle", 32'(pout), 32'hFF);
    endtask

    logic done = 1'b0;

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0;
        strap = 5'h13; pin = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_read();
        t_mismatch();
        t_cmd();
        t_length();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule